// File: doc/BRIEF.md
# Interrupt Coalescing and Credit Controller

This block is one interrupt vector. Event strobes from the function that owns the vector are turned into interrupt send pulses. A mask gates the sends. An optional auto-mask closes the mask after each send. A countdown holdoff timer spaces sends apart, and a signed credit counter records how many sends software has not yet acknowledged. An event that cannot be sent at once is held as pending. It goes out as soon as the vector is open again: the mask is clear and the holdoff timer is at zero.

Software programs the vector through a single-cycle register write port and a combinational read port. The holdoff value is counted in timebase ticks, with one tick per microsecond. Software acknowledges work by writing a count to the credit register, and that count is subtracted from the counter. When the counter falls to zero, any pending but unsent event is dropped. The same write can also clear the mask, reload the holdoff timer, or do both. Doing both rearms the vector.

Top module: `irqc_top`

## Requirements
- R1: After reset the registers read as follows: mask 1, holdoff value 0, credits 0, auto-mask 0, timer 0, pending 0. The send pulse is low. The register addresses are 0 holdoff value, 1 mask (bit 0), 2 credits, 3 auto-mask (bit 0), 4 timer (read-only), and 5 pending status (bit 0). All other addresses read as 0.
- R2: While the mask is 1, an event strobe raises no send pulse and sets the pending status to 1.
- R3: When the mask is 0 and the timer is 0, an event strobe, or an event already pending, gives `irqSend` high for exactly the clock cycle after the decision cycle. The pending status clears in that same cycle.
- R4: A send loads the timer with the holdoff value. While the timer is nonzero, nothing is sent. Each cycle with `tickUs` high lowers the timer by one, and the timer stays at 0 rather than wrapping.
- R5: If an event is pending when the timer reaches 0, it is sent on the cycle after the timer first reads 0. No new strobe is needed.
- R6: With a holdoff value of c and the event strobe and tick held high, successive sends are c+1 cycles apart. With c = 0, a send is made on every cycle.
- R7: Holdoff values above 63 are stored as 63. Values 0 to 63 are stored as written, in bits 5:0.
- R8: Each send adds one to the credit count. A write to the credit register subtracts `regWrData[15:0]` from the count, modulo 2^16. Reading the credit register returns the count in two's complement in bits 15:0, with bits 31:16 reading 0.
- R9: When the credit count moves from nonzero to zero, the pending status clears and the held event is never sent. A count that is nonzero, including a negative count, leaves the pending event in place.
- R10: In a credit write, bit 16 clears the mask and bit 17 reloads the timer from the holdoff value. Writing both bits together rearms the vector.
- R11: With auto-mask at 1, every send sets the mask to 1.
- R12: A send and a credit write in the same cycle both take effect: the new count is the old count plus one minus the written count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 1 | Interrupt event assertion, one per cycle high |
| tickUs | input | 1 | Timebase tick, one per microsecond |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| irqSend | output | 1 | One-cycle interrupt send pulse |

## Verification
A wrong mask, pending bit or timer value shows at the ports through `irqSend`. A send appears or goes missing one cycle after the decision cycle. The timer and status readbacks show the same fault on the next register read. A wrong credit sum can be read at once through the credit register. A wrong zero-crossing only shows when a held event fails to go out, or goes out when it should not, once the vector is next open. The bench therefore sweeps the holdoff values 0 to 6 and measures the spacing between sends in cycles. It also checks the held event after every credit write that reaches zero or stops short of zero.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_COAL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CRED  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MOA   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TIMER = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd5;

  localparam int UNMASK_BIT = 16;
  localparam int RELOAD_BIT = 17;

  typedef struct packed {
    logic fire;
    logic coalWr;
    logic credWr;
    logic timerReload;
  } strobes_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStrobe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  input  logic              wrUnmask,
  input  logic              wrReload,
  input  logic              timerZero,
  input  logic              credToZero,
  output strobes_t          strobes,
  output logic              maskQ,
  output logic              moaQ,
  output logic              pendQ,
  output logic              irqSend
);
  logic wrMask, wrCred, wrMoa, wrCoal;
  logic fire;
  logic pendNext, maskNext, moaNext;

  assign wrMask = regWrEn && (regAddr == ADDR_MASK);
  assign wrCred = regWrEn && (regAddr == ADDR_CRED);
  assign wrMoa  = regWrEn && (regAddr == ADDR_MOA);
  assign wrCoal = regWrEn && (regAddr == ADDR_COAL);

  // vector open and something to send
  assign fire = !maskQ && timerZero && (pendQ || evtStrobe);

  always_comb begin
    strobes.fire        = fire;
    strobes.coalWr      = wrCoal;
    strobes.credWr      = wrCred;
    strobes.timerReload = wrCred && wrReload;
  end

  always_comb begin
    pendNext = pendQ;
    if (fire)           pendNext = 1'b0;
    else if (evtStrobe) pendNext = 1'b1;
    // credit count reaching zero discards the held event
    if (credToZero)     pendNext = 1'b0;
  end

  always_comb begin
    maskNext = maskQ;
    if (fire && moaQ)          maskNext = 1'b1;
    // software writes take precedence over auto-mask
    if (wrMask)                maskNext = wrBit0;
    if (wrCred && wrUnmask)    maskNext = 1'b0;
  end

  always_comb begin
    moaNext = moaQ;
    if (wrMoa) moaNext = wrBit0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= 1'b1;
      moaQ    <= 1'b0;
      pendQ   <= 1'b0;
      irqSend <= 1'b0;
    end else begin
      maskQ   <= maskNext;
      moaQ    <= moaNext;
      pendQ   <= pendNext;
      irqSend <= fire;
    end
  end
endmodule

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int COAL_W = 6,
  parameter int CRED_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              tickUs,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              maskQ,
  input  logic              moaQ,
  input  logic              pendQ,
  output logic              timerZero,
  output logic              credToZero,
  output logic [COAL_W-1:0] coalQ,
  output logic [COAL_W-1:0] timerQ,
  output logic [CRED_W-1:0] credQ,
  output logic [DATA_W-1:0] regRdData
);
  localparam logic [COAL_W-1:0] COAL_MAX = {COAL_W{1'b1}};

  logic [COAL_W-1:0] coalWrVal;
  logic [COAL_W-1:0] timerNext;
  logic [CRED_W-1:0] credInc, credSub, credNext;

  // saturate out-of-range holdoff writes
  always_comb begin
    if (regWrData[DATA_W-1:COAL_W] != '0) coalWrVal = COAL_MAX;
    else                                  coalWrVal = regWrData[COAL_W-1:0];
  end

  assign timerZero = (timerQ == '0);

  always_comb begin
    timerNext = timerQ;
    if (strobes.fire || strobes.timerReload) timerNext = coalQ;
    else if (tickUs && !timerZero)           timerNext = timerQ - COAL_W'(1);
  end

  assign credInc    = {{(CRED_W-1){1'b0}}, strobes.fire};
  assign credSub    = strobes.credWr ? regWrData[CRED_W-1:0] : '0;
  assign credNext   = credQ + credInc - credSub;
  assign credToZero = (credQ != '0) && (credNext == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coalQ  <= '0;
      timerQ <= '0;
      credQ  <= '0;
    end else begin
      if (strobes.coalWr) coalQ <= coalWrVal;
      timerQ <= timerNext;
      credQ  <= credNext;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_COAL:  regRdData = DATA_W'(coalQ);
      ADDR_MASK:  regRdData = DATA_W'(maskQ);
      ADDR_CRED:  regRdData = DATA_W'(credQ);
      ADDR_MOA:   regRdData = DATA_W'(moaQ);
      ADDR_TIMER: regRdData = DATA_W'(timerQ);
      ADDR_STAT:  regRdData = DATA_W'(pendQ);
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int COAL_W = 6,
  parameter int CRED_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStrobe,
  input  logic              tickUs,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqSend
);
  strobes_t          strobes;
  logic              maskQ, moaQ, pendQ;
  logic              timerZero, credToZero;
  logic [COAL_W-1:0] coalQ, timerQ;
  logic [CRED_W-1:0] credQ;

  irqc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evtStrobe  (evtStrobe),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .wrBit0     (regWrData[0]),
    .wrUnmask   (regWrData[UNMASK_BIT]),
    .wrReload   (regWrData[RELOAD_BIT]),
    .timerZero  (timerZero),
    .credToZero (credToZero),
    .strobes    (strobes),
    .maskQ      (maskQ),
    .moaQ       (moaQ),
    .pendQ      (pendQ),
    .irqSend    (irqSend)
  );

  irqc_dpath #(
    .COAL_W (COAL_W),
    .CRED_W (CRED_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tickUs     (tickUs),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .maskQ      (maskQ),
    .moaQ       (moaQ),
    .pendQ      (pendQ),
    .timerZero  (timerZero),
    .credToZero (credToZero),
    .coalQ      (coalQ),
    .timerQ     (timerQ),
    .credQ      (credQ),
    .regRdData  (regRdData)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int COAL_W = 6,
  parameter int CRED_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqSend,
  input logic              maskQ,
  input logic              moaQ,
  input logic              pendQ,
  input logic [COAL_W-1:0] timerQ,
  input logic [COAL_W-1:0] coalQ,
  input logic [CRED_W-1:0] credQ,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr
);
  logic credWr;
  assign credWr = regWrEn && (regAddr == ADDR_CRED);

  assert_send_when_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqSend |-> ($past(!maskQ) && ($past(timerQ) == '0)));

  assert_send_loads_timer_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqSend |-> (timerQ == $past(coalQ)));

  assert_timer_no_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (timerQ != $past(timerQ)) |->
      ((($past(timerQ) != '0) && (timerQ == $past(timerQ) - COAL_W'(1))) ||
       (timerQ == $past(coalQ))));

  assert_credit_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(credWr) |-> (credQ == CRED_W'($past(credQ) + CRED_W'(irqSend))));

  assert_zero_drops_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((credQ == '0) && ($past(credQ) != '0)) |-> !pendQ);

  assert_auto_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqSend && $past(moaQ) && !$past(regWrEn)) |-> maskQ);
endmodule

bind irqc_top irqc_chk #(
  .COAL_W (COAL_W),
  .CRED_W (CRED_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .irqSend (irqSend),
  .maskQ   (maskQ),
  .moaQ    (moaQ),
  .pendQ   (pendQ),
  .timerQ  (timerQ),
  .coalQ   (coalQ),
  .credQ   (credQ),
  .regWrEn (regWrEn),
  .regAddr (regAddr)
);

// File: tb/irqc_top_bench.sv
`timescale 1ns/100ps
module irqc_top_bench;
  localparam real CLK_PERIOD = 5.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtStrobe = 1'b0;
  logic        tickUs = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        irqSend;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_COAL = 3'd0, A_MASK = 3'd1, A_CRED = 3'd2,
                         A_MOA = 3'd3, A_TIMER = 3'd4, A_STAT = 3'd5;

  irqc_top u_irqc_top (
    .clk       (clk),
    .rstN      (rstN),
    .evtStrobe (evtStrobe),
    .tickUs    (tickUs),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqSend   (irqSend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; regWrData = 32'd0;
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.5;
    check(tag, regRdData, exp);
  endtask

  task automatic pulseEvt();
    evtStrobe = 1'b1;
    step();
    evtStrobe = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickUs = 1'b1;
    for (int i = 0; i < n; i++) step();
    tickUs = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    logic [31:0] credBase;
    int gap;
    int waitN;

    step(); step();
    rstN = 1'b1;
    step();

    // R1: reset state
    check("R1 irqSend", {31'd0, irqSend}, 32'd0);
    chkReg("R1 mask", A_MASK, 32'd1);
    chkReg("R1 coal", A_COAL, 32'd0);
    chkReg("R1 cred", A_CRED, 32'd0);
    chkReg("R1 moa", A_MOA, 32'd0);
    step();
    chkReg("R1 timer", A_TIMER, 32'd0);
    chkReg("R1 status", A_STAT, 32'd0);
    chkReg("R1 unused addr", 3'd6, 32'd0);

    // R2: masked events only pend
    pulseEvt();
    check("R2 no send", {31'd0, irqSend}, 32'd0);
    step();
    check("R2 no send later", {31'd0, irqSend}, 32'd0);
    chkReg("R2 status", A_STAT, 32'd1);

    // R3: unmask sends the pending event
    wr(A_MASK, 32'd0);
    check("R3 not yet", {31'd0, irqSend}, 32'd0);
    step();
    check("R3 send", {31'd0, irqSend}, 32'd1);
    chkReg("R3 status cleared", A_STAT, 32'd0);
    chkReg("R8 cred after send", A_CRED, 32'd1);
    step();
    check("R3 single pulse", {31'd0, irqSend}, 32'd0);

    // R7: clamp
    wr(A_COAL, 32'd100);
    chkReg("R7 clamp", A_COAL, 32'd63);
    wr(A_COAL, 32'h0001_0000);
    chkReg("R7 clamp high bit", A_COAL, 32'd63);
    wr(A_COAL, 32'd5);
    chkReg("R7 in range", A_COAL, 32'd5);

    // R4/R5: holdoff and pending release
    pulseEvt();
    check("R3 event send", {31'd0, irqSend}, 32'd1);
    chkReg("R4 timer loaded", A_TIMER, 32'd5);
    chkReg("R8 cred 2", A_CRED, 32'd2);
    pulseEvt();
    check("R4 held", {31'd0, irqSend}, 32'd0);
    chkReg("R4 pending", A_STAT, 32'd1);
    tickUs = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      step();
      chkReg("R4 countdown", A_TIMER, 32'(5 - i));
      check("R4 no send in holdoff", {31'd0, irqSend}, 32'd0);
    end
    tickUs = 1'b0;
    step();
    check("R5 release", {31'd0, irqSend}, 32'd1);
    chkReg("R5 status", A_STAT, 32'd0);
    chkReg("R8 cred 3", A_CRED, 32'd3);

    // R4: no wrap
    ticks(7);
    chkReg("R4 floor", A_TIMER, 32'd0);
    check("R4 floor no send", {31'd0, irqSend}, 32'd0);

    // R8: credit subtraction and signed readback
    wr(A_CRED, 32'd1);
    chkReg("R8 sub 1", A_CRED, 32'd2);
    wr(A_CRED, 32'd5);
    chkReg("R8 negative", A_CRED, 32'h0000_FFFD);
    wr(A_CRED, 32'h0000_FFFD);
    chkReg("R8 back to zero", A_CRED, 32'd0);

    // R9: zero crossing drops pending
    wr(A_MASK, 32'd1);
    pulseEvt();
    chkReg("R9 pend set", A_STAT, 32'd1);
    wr(A_CRED, 32'h0000_FFFF);
    chkReg("R9 cred one", A_CRED, 32'd1);
    chkReg("R9 nonzero keeps pend", A_STAT, 32'd1);
    wr(A_CRED, 32'd1);
    chkReg("R9 zero drops pend", A_STAT, 32'd0);
    wr(A_CRED, 32'h0001_0000);
    chkReg("R10 unmask flag", A_MASK, 32'd0);
    step(); step();
    check("R9 dropped never sent", {31'd0, irqSend}, 32'd0);

    // R10: reload flag
    wr(A_CRED, 32'h0002_0000);
    chkReg("R10 reload", A_TIMER, 32'd5);
    pulseEvt();
    check("R10 held by reload", {31'd0, irqSend}, 32'd0);
    ticks(2);
    chkReg("R10 partial", A_TIMER, 32'd3);
    wr(A_CRED, 32'h0002_0000);
    chkReg("R10 reload again", A_TIMER, 32'd5);
    chkReg("R10 pend kept", A_STAT, 32'd1);
    ticks(5);
    check("R10 no early send", {31'd0, irqSend}, 32'd0);
    step();
    check("R5 send after reload", {31'd0, irqSend}, 32'd1);
    chkReg("R8 cred 1", A_CRED, 32'd1);

    // R11: auto-mask, then rearm
    wr(A_MOA, 32'd1);
    chkReg("R11 moa", A_MOA, 32'd1);
    ticks(5);
    pulseEvt();
    check("R11 send", {31'd0, irqSend}, 32'd1);
    chkReg("R11 masked", A_MASK, 32'd1);
    pulseEvt();
    check("R11 held by mask", {31'd0, irqSend}, 32'd0);
    wr(A_CRED, 32'h0003_0000);
    chkReg("R10 rearm mask", A_MASK, 32'd0);
    chkReg("R10 rearm timer", A_TIMER, 32'd5);
    chkReg("R10 rearm pend", A_STAT, 32'd1);
    chkReg("R10 rearm cred", A_CRED, 32'd2);
    ticks(5);
    step();
    check("R11 rearm send", {31'd0, irqSend}, 32'd1);
    chkReg("R11 masked again", A_MASK, 32'd1);
    chkReg("R8 cred 3b", A_CRED, 32'd3);

    // R12: concurrent send and credit write
    wr(A_MOA, 32'd0);
    wr(A_MASK, 32'd0);
    wr(A_COAL, 32'd0);
    wr(A_CRED, 32'h0002_0000);
    chkReg("R12 timer zero", A_TIMER, 32'd0);
    evtStrobe = 1'b1;
    wr(A_CRED, 32'd3);
    evtStrobe = 1'b0;
    check("R12 send", {31'd0, irqSend}, 32'd1);
    chkReg("R12 cred", A_CRED, 32'd1);
    step();

    // R6: holdoff sweep, spacing c+1
    regAddr = A_CRED;
    #0.5;
    credBase = regRdData;
    for (int c = 0; c <= 6; c++) begin
      wr(A_COAL, 32'(c));
      tickUs = 1'b1;
      evtStrobe = 1'b1;
      waitN = 0;
      while (!irqSend && waitN < 100) begin step(); waitN++; end
      gap = 0;
      do begin step(); gap++; end while (!irqSend && gap < 100);
      evtStrobe = 1'b0;
      tickUs = 1'b0;
      check("R6 spacing", 32'(gap), 32'(c + 1));
      chkReg("R4 sweep load", A_TIMER, 32'(c));
      step();
    end
    chkReg("R8 sweep cred", A_CRED, credBase + 32'd14);

    done = 1'b1;
    finishRun();
  end
endmodule